// File: doc/BRIEF.md
# Snooping Write-Through Cache Cluster

This block is a four-core shared-memory subsystem. Each core reaches memory through a small private cache. The cache is direct-mapped and holds one word per line, with a tag and a valid bit. All caches reach a single word-addressed memory array over one shared bus. A round-robin arbiter admits one transaction per cycle to that bus. Stores and read misses must win the bus. A load that hits its own cache is served locally and needs no grant. Every store writes memory in the cycle it holds the bus.

Every cache watches every store on the bus. The `snoop_mode` pin is sampled each cycle and selects how the other caches react. In invalidate mode (0), any other cache that holds the stored address drops its copy, so its next load misses and refills from memory. In update mode (1), those caches overwrite their copy with the broadcast data and keep it valid. The snoop action lands on the same clock edge as the memory write. A load accepted after that edge can therefore never see the old value.

Each core port is a request channel with valid and ready, plus a response strobe for loads. A core raises `core_req_valid` and holds the operation, address and data steady until it sees `core_req_ready` high at a clock edge. That is the only back-pressure. Stores complete on acceptance and return nothing. A load returns its word on `core_rsp_data` with a single-cycle `core_rsp_valid` in the cycle after acceptance. The response path has no back-pressure.

Top module: `coh_cluster`

## Requirements
- R1: After reset, every cache is empty and every memory word reads 0. With no request pending, `core_req_ready` and `core_rsp_valid` are low for all cores.
- R2: Stores are write-through: memory takes the new word when the store is accepted. A later load of that address by any core returns the most recently stored value.
- R3: An accepted load raises `core_rsp_valid` for exactly one cycle, the cycle after acceptance, with the data. An accepted store produces no response.
- R4: A load that hits its own cache is accepted in the cycle it is presented, even while another core owns the bus in that same cycle.
- R5: In invalidate mode (`snoop_mode`=0), a store by one core removes a matching line from every other cache. That other core's next load of the address must go to the bus, so it cannot be accepted in the same cycle as a concurrent bus store by another core, and it returns the new value.
- R6: In update mode (`snoop_mode`=1), a store by one core overwrites a matching line in every other cache and keeps it valid. That other core's next load of the address hits and returns the new value.
- R7: A store that misses the writing core's cache writes memory only and does not allocate a line. A following load of that address by the same core misses.
- R8: A store that hits the writing core's cache updates that line in both modes. The next load of that address by the same core hits with the new value.
- R9: A snooped store whose address has the same line index but a different tag leaves the snooping cache's line unchanged, in both modes.
- R10: The bus is granted round-robin. Priority starts at the core after the last one granted, and core 0 has first priority after reset.
- R11: At most one core is granted the bus in any cycle, and only a core that needs the bus is granted.
- R12: A core holds its request unchanged until it is accepted, and every held request is eventually accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| snoop_mode | input | 1 | 0: invalidate other copies on a store; 1: update other copies |
| core_req_valid | input | NCORES | Per-core request valid |
| core_req_write | input | NCORES | Per-core operation: 1 store, 0 load |
| core_req_addr | input | NCORES x AW | Per-core word address (low IDXW bits select the line, upper bits are the tag) |
| core_req_wdata | input | NCORES x DW | Per-core store data |
| core_req_ready | output | NCORES | Per-core request accepted at this edge |
| core_rsp_valid | output | NCORES | Per-core one-cycle load response strobe |
| core_rsp_data | output | NCORES x DW | Per-core load data, meaningful while the strobe is high |

## Verification
A fixed script of single-core loads and stores in invalidate mode pits reads against writes from other cores at the same address. A stale copy would show up as a wrong returned value. Pairs of requests presented in the same cycle separate a hit from a miss: a load that hits is accepted alongside a granted bus store, while a load that misses is accepted in a different cycle. This pattern tells invalidation from update, no allocation on a store miss, and a same-index foreign store from a true match. Simultaneous bus requests from all four cores, and from a subset after a known last winner, expose the grant order.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // Reaction of the non-writing caches to a store seen on the bus
  typedef enum logic {
    SNOOP_INVALIDATE = 1'b0,
    SNOOP_UPDATE     = 1'b1
  } snoop_mode_e;
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] cand;
  logic          found;

  // search starts one past the most recent winner
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    cand    = '0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last_q) + k) % N);
      if (!found && req[cand]) begin
        gnt[cand] = 1'b1;
        gnt_idx   = cand;
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= IW'(N - 1);
    else if (found)  last_q <= gnt_idx;
  end
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/coh_cache.sv
module coh_cache
  import coh_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int IDXW = 2,
  parameter int SRCW = 2,
  parameter int ID   = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  snoop_mode_e     mode,
  // core side
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  // bus side
  output logic            bus_req,
  input  logic            bus_gnt,
  input  logic [DW-1:0]   fill_data,
  input  logic            snp_valid,
  input  logic            snp_write,
  input  logic [SRCW-1:0] snp_src,
  input  logic [AW-1:0]   snp_addr,
  input  logic [DW-1:0]   snp_data
);
  localparam int LINES = 1 << IDXW;
  localparam int TW    = AW - IDXW;

  logic [LINES-1:0] vld_q;
  logic [TW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  logic [IDXW-1:0] r_idx, s_idx;
  logic [TW-1:0]   r_tag, s_tag;
  logic            r_hit, ld_hit, own_op, snp_match, ld_take;

  assign r_idx = req_addr[IDXW-1:0];
  assign r_tag = req_addr[AW-1:IDXW];
  assign s_idx = snp_addr[IDXW-1:0];
  assign s_tag = snp_addr[AW-1:IDXW];

  assign r_hit   = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign ld_hit  = req_valid && !req_write && r_hit;
  assign bus_req = req_valid && !ld_hit;
  assign own_op  = req_valid && bus_gnt;
  assign req_ready = ld_hit || own_op;
  assign ld_take = req_valid && !req_write && req_ready;

  // a store from another core whose address this cache holds
  assign snp_match = snp_valid && snp_write && (snp_src != SRCW'(ID)) &&
                     vld_q[s_idx] && (tag_q[s_idx] == s_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (snp_match) begin
        if (mode == SNOOP_UPDATE) dat_q[s_idx] <= snp_data;
        else                      vld_q[s_idx] <= 1'b0;
      end
      if (own_op) begin
        if (req_write) begin
          if (r_hit) dat_q[r_idx] <= req_wdata;   // no allocate on miss
        end else begin
          vld_q[r_idx] <= 1'b1;
          tag_q[r_idx] <= r_tag;
          dat_q[r_idx] <= fill_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= ld_take;
  end

  always_ff @(posedge clk) begin
    if (ld_take) rsp_data <= ld_hit ? dat_q[r_idx] : fill_data;
  end
endmodule

// File: rtl/coh_cluster.sv
module coh_cluster
  import coh_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int IDXW   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       snoop_mode,
  input  logic [NCORES-1:0]          core_req_valid,
  input  logic [NCORES-1:0]          core_req_write,
  input  logic [NCORES-1:0][AW-1:0]  core_req_addr,
  input  logic [NCORES-1:0][DW-1:0]  core_req_wdata,
  output logic [NCORES-1:0]          core_req_ready,
  output logic [NCORES-1:0]          core_rsp_valid,
  output logic [NCORES-1:0][DW-1:0]  core_rsp_data
);
  localparam int SRCW = (NCORES > 1) ? $clog2(NCORES) : 1;

  logic [NCORES-1:0] bus_req, bus_gnt;
  logic [SRCW-1:0]   bus_src;
  logic              bus_valid, bus_write;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_wdata, mem_rdata;
  snoop_mode_e       mode;

  assign mode = snoop_mode_e'(snoop_mode);

  coh_rr_arbiter #(.N(NCORES), .IW(SRCW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bus_req),
    .gnt     (bus_gnt),
    .gnt_idx (bus_src)
  );

  assign bus_valid = |bus_gnt;
  assign bus_write = core_req_write[bus_src];
  assign bus_addr  = core_req_addr[bus_src];
  assign bus_wdata = core_req_wdata[bus_src];

  coh_memory #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_valid && bus_write),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (mem_rdata)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    coh_cache #(
      .AW(AW), .DW(DW), .IDXW(IDXW), .SRCW(SRCW), .ID(c)
    ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .req_valid (core_req_valid[c]),
      .req_write (core_req_write[c]),
      .req_addr  (core_req_addr[c]),
      .req_wdata (core_req_wdata[c]),
      .req_ready (core_req_ready[c]),
      .rsp_valid (core_rsp_valid[c]),
      .rsp_data  (core_rsp_data[c]),
      .bus_req   (bus_req[c]),
      .bus_gnt   (bus_gnt[c]),
      .fill_data (mem_rdata),
      .snp_valid (bus_valid),
      .snp_write (bus_write),
      .snp_src   (bus_src),
      .snp_addr  (bus_addr),
      .snp_data  (bus_wdata)
    );
  end
endmodule

// File: rtl/coh_cluster_chk.sv
module coh_cluster_chk #(
  parameter int NCORES = 4,
  parameter int AW     = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCORES-1:0]         core_req_valid,
  input logic [NCORES-1:0]         core_req_write,
  input logic [NCORES-1:0][AW-1:0] core_req_addr,
  input logic [NCORES-1:0]         core_req_ready,
  input logic [NCORES-1:0]         core_rsp_valid,
  input logic [NCORES-1:0]         bus_req,
  input logic [NCORES-1:0]         bus_gnt
);
  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  // R11
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt & ~bus_req) == '0);

  // R3
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      core_rsp_valid == $past(core_req_valid & core_req_ready & ~core_req_write));

  // R10
  rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(bus_gnt) != '0) && ((bus_req & ~$past(bus_gnt)) != '0))
      |-> ((bus_gnt & $past(bus_gnt)) == '0));

  for (genvar g = 0; g < NCORES; g++) begin : g_hold
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req_valid[g] && !core_req_ready[g]) |=>
        (core_req_valid[g] && $stable(core_req_addr[g]) && $stable(core_req_write[g])));
  end
endmodule

bind coh_cluster coh_cluster_chk #(.NCORES(NCORES), .AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_write (core_req_write),
  .core_req_addr  (core_req_addr),
  .core_req_ready (core_req_ready),
  .core_rsp_valid (core_rsp_valid),
  .bus_req        (bus_req),
  .bus_gnt        (bus_gnt)
);

// File: tb/coh_cluster_test.sv
`timescale 1ns/1ps
module coh_cluster_test;
  localparam int NC = 4;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic snoop_mode;
  logic [NC-1:0]         core_req_valid, core_req_write;
  logic [NC-1:0][AW-1:0] core_req_addr;
  logic [NC-1:0][DW-1:0] core_req_wdata;
  logic [NC-1:0]         core_req_ready, core_rsp_valid;
  logic [NC-1:0][DW-1:0] core_rsp_data;

  always #2 clk = ~clk;

  coh_cluster #(.NCORES(NC), .AW(AW), .DW(DW), .IDXW(2)) uut (
    .clk(clk), .rst_n(rst_n), .snoop_mode(snoop_mode),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
    .core_req_ready(core_req_ready), .core_rsp_valid(core_rsp_valid),
    .core_rsp_data(core_rsp_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // stimulus for one round of concurrent requests
  logic [NC-1:0]         m_en, m_wr;
  logic [NC-1:0][AW-1:0] m_addr;
  logic [NC-1:0][DW-1:0] m_wd;
  int                    acc_cyc [NC];
  logic [DW-1:0]         got     [NC];

  task automatic run_multi();
    logic [NC-1:0] pend, just;
    int cyc;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      core_req_valid[i] = m_en[i];
      core_req_write[i] = m_wr[i];
      core_req_addr[i]  = m_addr[i];
      core_req_wdata[i] = m_wd[i];
      acc_cyc[i] = -1;
      got[i] = '0;
    end
    pend = m_en; just = '0; cyc = 0;
    while ((pend != '0 || just != '0) && cyc < 40) begin
      #1;
      for (int i = 0; i < NC; i++) begin
        if (just[i]) begin
          // R3: strobe only for loads, the cycle after acceptance
          chk(core_rsp_valid[i] == !m_wr[i], "R3 response strobe", int'(core_rsp_valid[i]), int'(!m_wr[i]));
          if (!m_wr[i]) got[i] = core_rsp_data[i];
        end
      end
      just = '0;
      for (int i = 0; i < NC; i++) begin
        if (pend[i] && core_req_ready[i]) begin
          acc_cyc[i] = cyc;
          just[i] = 1'b1;
          pend[i] = 1'b0;
        end
      end
      @(negedge clk);
      for (int i = 0; i < NC; i++) if (just[i]) core_req_valid[i] = 1'b0;
      cyc++;
    end
    // R12: every held request got accepted
    chk(pend == '0, "R12 held request accepted", int'(pend), 0);
    #1;
    // R3: strobe lasted a single cycle
    chk(core_rsp_valid == '0, "R3 strobe single cycle", int'(core_rsp_valid), 0);
    core_req_valid = '0;
  endtask

  task automatic clear_m();
    m_en = '0; m_wr = '0; m_addr = '0; m_wd = '0;
  endtask

  task automatic add_op(input int c, input bit wr, input int a, input int d);
    m_en[c] = 1'b1; m_wr[c] = wr; m_addr[c] = AW'(a); m_wd[c] = DW'(d);
  endtask

  task automatic single(input int c, input bit wr, input int a, input int d);
    clear_m(); add_op(c, wr, a, d); run_multi();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    core_req_valid = '0; core_req_write = '0; core_req_addr = '0; core_req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic [1:0]    core;
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] dat;   // store data, or expected load data
  } vec_t;

  // invalidate-mode script: write-through and stale-copy removal
  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b0, 6'd5,  16'h0000},
    '{2'd1, 1'b1, 6'd5,  16'h1111},
    '{2'd0, 1'b0, 6'd5,  16'h1111},
    '{2'd2, 1'b0, 6'd5,  16'h1111},
    '{2'd2, 1'b1, 6'd5,  16'h2222},
    '{2'd1, 1'b0, 6'd5,  16'h2222},
    '{2'd0, 1'b0, 6'd5,  16'h2222},
    '{2'd3, 1'b1, 6'd9,  16'h3333},
    '{2'd3, 1'b0, 6'd9,  16'h3333},
    '{2'd0, 1'b0, 6'd13, 16'h0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    snoop_mode = 1'b0;
    do_reset();
    #1;
    // R1: idle after reset
    chk(core_rsp_valid == '0, "R1 no response after reset", int'(core_rsp_valid), 0);
    chk(core_req_ready == '0, "R1 no ready when idle", int'(core_req_ready), 0);

    for (int v = 0; v < 10; v++) begin
      single(int'(VECS[v].core), VECS[v].wr, int'(VECS[v].addr), int'(VECS[v].dat));
      if (!VECS[v].wr)
        // R1 (zero memory) R2 R5 (newest value after another core's store)
        chk(got[VECS[v].core] == VECS[v].dat, "R2 R5 load value", int'(got[VECS[v].core]), int'(VECS[v].dat));
    end

    // R10 R11: four simultaneous stores right after reset
    do_reset();
    clear_m();
    for (int i = 0; i < NC; i++) add_op(i, 1'b1, 50 + i, 16'h5000 + i);
    run_multi();
    for (int i = 0; i < NC; i++)
      chk(acc_cyc[i] == i, "R10 R11 grant order from reset", acc_cyc[i], i);

    // R10: after core 2 wins, order is 3, 0, 1
    single(2, 1'b1, 54, 16'h5400);
    clear_m();
    add_op(0, 1'b1, 55, 1); add_op(1, 1'b1, 56, 2); add_op(3, 1'b1, 57, 3);
    run_multi();
    chk(acc_cyc[3] == 0, "R10 core 3 first", acc_cyc[3], 0);
    chk(acc_cyc[0] == 1, "R10 core 0 second", acc_cyc[0], 1);
    chk(acc_cyc[1] == 2, "R10 core 1 third", acc_cyc[1], 2);

    // R8 R4: own store hit, then hit concurrently with a bus store
    single(0, 1'b0, 20, 0);
    single(0, 1'b1, 20, 16'hAAAA);
    clear_m(); add_op(0, 1'b0, 20, 0); add_op(1, 1'b1, 30, 16'h3030);
    run_multi();
    chk(acc_cyc[0] == 0 && acc_cyc[1] == 0, "R4 R8 hit beside bus store", acc_cyc[0], 0);
    chk(got[0] == 16'hAAAA, "R8 own copy updated", int'(got[0]), 16'hAAAA);

    // R5: invalidate removes core 1's copy
    single(1, 1'b0, 20, 0);
    chk(got[1] == 16'hAAAA, "R2 fill from memory", int'(got[1]), 16'hAAAA);
    single(0, 1'b1, 20, 16'hBBBB);
    clear_m(); add_op(1, 1'b0, 20, 0); add_op(2, 1'b1, 31, 16'h3131);
    run_multi();
    chk(acc_cyc[1] != acc_cyc[2], "R5 invalidated load misses", acc_cyc[1], acc_cyc[2] + 1);
    chk(got[1] == 16'hBBBB, "R5 refill returns new value", int'(got[1]), 16'hBBBB);

    // R6: update keeps core 1's copy valid with new data
    snoop_mode = 1'b1;
    single(0, 1'b1, 20, 16'hCCCC);
    clear_m(); add_op(1, 1'b0, 20, 0); add_op(3, 1'b1, 32, 16'h3232);
    run_multi();
    chk(acc_cyc[1] == 0 && acc_cyc[3] == 0, "R6 updated copy still hits", acc_cyc[1], 0);
    chk(got[1] == 16'hCCCC, "R6 updated data", int'(got[1]), 16'hCCCC);
    single(0, 1'b0, 20, 0);
    chk(got[0] == 16'hCCCC, "R8 own copy in update mode", int'(got[0]), 16'hCCCC);

    // R9: same index, different tag, both modes
    single(2, 1'b0, 21, 0);
    single(3, 1'b1, 25, 16'h5555);
    clear_m(); add_op(2, 1'b0, 21, 0); add_op(0, 1'b1, 33, 16'h3333);
    run_multi();
    chk(acc_cyc[2] == 0 && acc_cyc[0] == 0, "R9 update mode line kept", acc_cyc[2], 0);
    chk(got[2] == 16'h0000, "R9 update mode data kept", int'(got[2]), 0);
    snoop_mode = 1'b0;
    single(3, 1'b1, 25, 16'h6666);
    clear_m(); add_op(2, 1'b0, 21, 0); add_op(0, 1'b1, 34, 16'h3434);
    run_multi();
    chk(acc_cyc[2] == 0 && acc_cyc[0] == 0, "R9 invalidate mode line kept", acc_cyc[2], 0);
    chk(got[2] == 16'h0000, "R9 invalidate mode data kept", int'(got[2]), 0);

    // R7: store miss does not allocate
    single(3, 1'b1, 40, 16'h7777);
    clear_m(); add_op(3, 1'b0, 40, 0); add_op(0, 1'b1, 35, 16'h3535);
    run_multi();
    chk(acc_cyc[3] != acc_cyc[0], "R7 load after store miss misses", acc_cyc[3], acc_cyc[0] + 1);
    chk(got[3] == 16'h7777, "R7 R2 value from memory", int'(got[3]), 16'h7777);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule